// File: doc/BRIEF.md
# Framebuffer Fetch Engine

This block keeps a display pipeline supplied with pixel words. It reads the frame image from memory as fixed-length bursts of 32-bit words through a plain request/grant read port, queues the returned words in an internal FIFO, and hands them to a downstream pixel-unpacking stage over a valid/ready pair. It starts at a programmed base address. It steps through the frame word by word in rising address order and returns to the base when the programmed number of words has been fetched. A one-cycle marker tells the display side that a new frame has begun.

Refills are paced by FIFO free space. A burst is requested only when nothing is in flight and the free space is at least both a programmed threshold and the current burst length. The usual threshold setting is the FIFO depth less three more than twice the burst length. An enable input starts and stops fetching; stopping lets a granted burst complete. A separate restart input drops the engine back to its idle state at the base address and empties the FIFO.

Top module: `fbdma_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_req`, `pix_valid` and `frame_start` are 0.
- R2: The first burst of every frame is requested at `cfg_base_addr`, and `frame_start` is 1 for exactly the one cycle that follows the grant of that burst and 0 otherwise.
- R3: Within a frame each burst starts at the byte address that follows the last word of the previous one (4 bytes per word, little-endian word order), and words reach `pix_data` in rising address order.
- R4: A burst is `cfg_burst_m1`+1 words long, shortened to the words left in the frame; `mem_len_m1` carries the length minus one and exactly that many plus one beats are taken.
- R5: After `cfg_frame_words` words have been requested, the next request is again at `cfg_base_addr`.
- R6: A request is raised only when no burst is outstanding and FIFO free space is at least `cfg_threshold` and at least the burst length; with the consumer stalled, requests stop once free space falls below either.
- R7: Once raised, `mem_req` stays high with `mem_addr` and `mem_len_m1` unchanged until the cycle in which `mem_gnt` is 1.
- R8: The FIFO holds up to `FIFO_DEPTH` words, loses none, and returns them in arrival order; a word leaves when `pix_valid` and `pix_ready` are both 1.
- R9: With `cfg_enable` low, a granted burst still receives all of its beats and no new request is raised.
- R10: A cycle with `cfg_dma_reset` high empties the FIFO (`pix_valid` is 0 the next cycle) and the next request is at `cfg_base_addr` with a `frame_start` pulse.
- R11: `mem_rvalid` beats that arrive while no granted burst is taking data are discarded and never reach `pix_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows new bursts to be requested |
| cfg_dma_reset | input | 1 | Returns the engine to idle at the base address and flushes the FIFO |
| cfg_base_addr | input | 32 | Byte address of the first frame word |
| cfg_frame_words | input | 20 | Frame length in 32-bit words (at least 1) |
| cfg_burst_m1 | input | 4 | Burst length minus one |
| cfg_threshold | input | CNT_W | Minimum FIFO free space for a refill |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the burst's first word |
| mem_len_m1 | output | 4 | Burst length minus one |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | A read beat is present |
| mem_rdata | input | 32 | Read beat data |
| pix_valid | output | 1 | A word is available for the consumer |
| pix_ready | input | 1 | Consumer takes the word |
| pix_data | output | 32 | Oldest queued word |
| frame_start | output | 1 | One-cycle pulse after the first burst of a frame is granted |

## Verification
The bench aims at a frame length that is not a multiple of the burst, so the last burst of each frame is short; an engine that does not shorten it reads past the frame and its next request is not at the base. It stalls the consumer for long stretches so the free-space test decides, once with a threshold above the burst length and once with one far below it; a design that compares only one of the two would overfill the FIFO or request with too little room. It drops the enable right after a grant and injects stray read beats while idle; a design that aborts the burst would leave words missing, and one that accepts stray beats would put unexpected words into the pixel stream. A restart with a full FIFO must leave no word behind and must begin again at the base with a frame pulse.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

    parameter int FB_ADDR_W  = 32;
    parameter int FB_DATA_W  = 32;
    parameter int FB_BLEN_W  = 4;
    parameter int FB_FRAME_W = 20;

    localparam int FB_LEN_W      = FB_BLEN_W + 1;
    localparam int FB_WORD_BYTES = FB_DATA_W / 8;
    localparam int FB_BYTE_SHIFT = $clog2(FB_WORD_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic [FB_ADDR_W-1:0] addr;
        logic [FB_LEN_W-1:0]  len;
    } burst_desc_t;

    // shorter of the programmed burst and the words left in the frame
    function automatic logic [FB_LEN_W-1:0] clamp_len(
        input logic [FB_LEN_W-1:0]   want,
        input logic [FB_FRAME_W-1:0] left
    );
        if (FB_FRAME_W'(want) > left)
            return left[FB_LEN_W-1:0];
        return want;
    endfunction

    function automatic logic [FB_ADDR_W-1:0] words_to_bytes(
        input logic [FB_LEN_W-1:0] words
    );
        return FB_ADDR_W'(words) << FB_BYTE_SHIFT;
    endfunction

endpackage

// File: rtl/fbdma_fifo.sv
module fbdma_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] free
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push)
            store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = store[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign free  = CNT_W'(DEPTH) - count;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst || flush)
        push |-> !full)
        else $error("fifo written while full");

endmodule

// File: rtl/fbdma_addr_gen.sv
module fbdma_addr_gen
    import fbdma_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic [FB_ADDR_W-1:0]  cfg_base,
    input  logic [FB_FRAME_W-1:0] cfg_frame_words,
    input  logic [FB_BLEN_W-1:0]  cfg_burst_m1,
    input  logic                  take,
    output burst_desc_t           burst,
    output logic                  frame_head
);

    logic                  at_head;
    logic [FB_ADDR_W-1:0]  cur_addr;
    logic [FB_FRAME_W-1:0] words_left;

    logic [FB_ADDR_W-1:0]  eff_addr;
    logic [FB_FRAME_W-1:0] eff_left;
    logic [FB_LEN_W-1:0]   want;
    logic [FB_LEN_W-1:0]   len;
    logic                  ends_frame;

    // at a frame head the live configuration supplies address and length
    assign eff_addr   = at_head ? cfg_base : cur_addr;
    assign eff_left   = at_head ? cfg_frame_words : words_left;
    assign want       = FB_LEN_W'(cfg_burst_m1) + 1'b1;
    assign len        = clamp_len(want, eff_left);
    assign ends_frame = (FB_FRAME_W'(len) == eff_left);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            at_head    <= 1'b1;
            cur_addr   <= '0;
            words_left <= '0;
        end else if (take) begin
            at_head    <= ends_frame;
            cur_addr   <= eff_addr + words_to_bytes(len);
            words_left <= eff_left - FB_FRAME_W'(len);
        end
    end

    assign burst.addr = eff_addr;
    assign burst.len  = len;
    assign frame_head = at_head;

endmodule

// File: rtl/fbdma_burst_ctl.sv
module fbdma_burst_ctl
    import fbdma_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                enable,
    input  logic [CNT_W-1:0]    free,
    input  logic [CNT_W-1:0]    threshold,
    input  logic [FB_LEN_W-1:0] len,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    output logic                mem_req,
    output logic                take,
    output logic                push
);

    fetch_state_e        state, state_nx;
    logic [FB_LEN_W-1:0] beats_left;
    logic                room_ok;

    assign room_ok = (free >= threshold) && (32'(free) >= 32'(len));

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (enable && room_ok) state_nx = ST_REQ;
            ST_REQ:  if (mem_gnt) state_nx = ST_DATA;
            ST_DATA: if (mem_rvalid && beats_left == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state      <= ST_IDLE;
            beats_left <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_REQ && mem_gnt)
                beats_left <= len - 1'b1;
            else if (state == ST_DATA && mem_rvalid)
                beats_left <= beats_left - 1'b1;
        end
    end

    assign mem_req = (state == ST_REQ);
    assign take    = (state == ST_REQ) && mem_gnt;
    assign push    = (state == ST_DATA) && mem_rvalid;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst || restart)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE))
        else $error("left idle while disabled");

endmodule

// File: rtl/fbdma_engine.sv
module fbdma_engine
    import fbdma_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_enable,
    input  logic                  cfg_dma_reset,
    input  logic [FB_ADDR_W-1:0]  cfg_base_addr,
    input  logic [FB_FRAME_W-1:0] cfg_frame_words,
    input  logic [FB_BLEN_W-1:0]  cfg_burst_m1,
    input  logic [CNT_W-1:0]      cfg_threshold,
    output logic                  mem_req,
    output logic [FB_ADDR_W-1:0]  mem_addr,
    output logic [FB_BLEN_W-1:0]  mem_len_m1,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [FB_DATA_W-1:0]  mem_rdata,
    output logic                  pix_valid,
    input  logic                  pix_ready,
    output logic [FB_DATA_W-1:0]  pix_data,
    output logic                  frame_start
);

    burst_desc_t         burst;
    logic                frame_head;
    logic                take;
    logic                push;
    logic                fifo_empty;
    logic                fifo_full;
    logic [CNT_W-1:0]    fifo_free;
    logic [FB_LEN_W-1:0] len_m1_full;

    fbdma_addr_gen u_addr (
        .clk             (clk),
        .rst             (rst),
        .restart         (cfg_dma_reset),
        .cfg_base        (cfg_base_addr),
        .cfg_frame_words (cfg_frame_words),
        .cfg_burst_m1    (cfg_burst_m1),
        .take            (take),
        .burst           (burst),
        .frame_head      (frame_head)
    );

    fbdma_burst_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .restart    (cfg_dma_reset),
        .enable     (cfg_enable),
        .free       (fifo_free),
        .threshold  (cfg_threshold),
        .len        (burst.len),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .take       (take),
        .push       (push)
    );

    fbdma_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FB_DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (cfg_dma_reset),
        .push  (push),
        .wdata (mem_rdata),
        .pop   (pix_ready),
        .rdata (pix_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .free  (fifo_free)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_dma_reset)
            frame_start <= 1'b0;
        else
            frame_start <= take && frame_head;
    end

    assign len_m1_full = burst.len - 1'b1;
    assign mem_addr    = burst.addr;
    assign mem_len_m1  = len_m1_full[FB_BLEN_W-1:0];
    assign pix_valid   = !fifo_empty;

    // R2
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst || cfg_dma_reset)
        frame_start |-> $past(mem_req && mem_gnt))
        else $error("frame pulse without a grant");

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst || cfg_dma_reset)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len_m1)))
        else $error("request changed before grant");

    // R6
    req_room_chk: assert property (@(posedge clk) disable iff (rst || cfg_dma_reset)
        mem_req |-> (32'(fifo_free) >= 32'(burst.len)))
        else $error("request without room for the burst");

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst || cfg_dma_reset)
        fifo_full |-> !mem_req)
        else $error("request while fifo full");

endmodule

// File: tb/fbdma_engine_test.sv
module fbdma_engine_test;

    localparam int DEPTH = 32;
    localparam int CW    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_dma_reset = 1'b0;
    logic [31:0] cfg_base_addr = 32'h0000_1000;
    logic [19:0] cfg_frame_words = 20'd22;
    logic [3:0]  cfg_burst_m1 = 4'd3;
    logic [CW-1:0] cfg_threshold = 6'd21;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [3:0]  mem_len_m1;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [31:0] pix_data;
    logic        frame_start;

    always #2 clk = ~clk;

    fbdma_engine #(.FIFO_DEPTH(DEPTH)) uut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    logic [31:0] exp_q[$];
    int  widx = 0;
    int  wraps = 0;
    int  occ = 0;
    int  pend = 0;
    logic [31:0] beat_addr = '0;
    bit  last_push = 0, last_pop = 0;
    bit  fs_pending = 0;
    bit  req_seen = 0;
    bit  kill = 0, kill_seen = 0;
    bit  spur = 0;
    int  rmode = 0;   // 0 stall, 1 always, 2 random

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC001_D00D;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver side: expected words for one granted burst
    task automatic push_expected(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(mdata(a + 32'(4 * i)));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int bl, rem, lexp, freesp;
            logic [31:0] eaddr;
            occ = occ + int'(last_push) - int'(last_pop);
            last_push = 0;
            last_pop = 0;
            if (frame_start || fs_pending)
                check(frame_start == fs_pending, "R2 frame_start", 32'(frame_start), 32'(fs_pending));
            fs_pending = 0;
            // read beats
            mem_rvalid = 1'b0;
            if (pend > 0 && $urandom_range(3) != 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = mdata(beat_addr);
                beat_addr += 4;
                pend--;
                last_push = 1;
            end else if (spur && pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = 32'hDEAD_BEEF;
            end
            // request side
            mem_gnt = 1'b0;
            bl = int'(cfg_burst_m1) + 1;
            rem = int'(cfg_frame_words) - widx;
            lexp = (bl < rem) ? bl : rem;
            eaddr = cfg_base_addr + 32'(4 * widx);
            if (mem_req) begin
                if (!req_seen) begin
                    req_seen = 1;
                    freesp = DEPTH - occ;
                    check(pend == 0 && freesp >= int'(cfg_threshold) && freesp >= lexp,
                          "R6 room at request", 32'(freesp), 32'(lexp));
                end
                if ($urandom_range(1) == 1) begin
                    mem_gnt = 1'b1;
                    req_seen = 0;
                    check(mem_addr == eaddr, "R3 burst address", mem_addr, eaddr);
                    check(int'(mem_len_m1) + 1 == lexp, "R4 burst length", 32'(mem_len_m1) + 1, 32'(lexp));
                    if (widx == 0)
                        check(mem_addr == cfg_base_addr, "R5 frame head at base", mem_addr, cfg_base_addr);
                    push_expected(eaddr, lexp);
                    beat_addr = mem_addr;
                    pend = int'(mem_len_m1) + 1;
                    fs_pending = (widx == 0);
                    widx += lexp;
                    if (widx >= int'(cfg_frame_words)) begin
                        widx = 0;
                        wraps++;
                    end
                    if (kill) begin
                        cfg_enable = 1'b0;
                        kill = 0;
                        kill_seen = 1;
                    end
                end
            end
            // monitor / consumer
            case (rmode)
                0: pix_ready = 1'b0;
                1: pix_ready = 1'b1;
                default: pix_ready = ($urandom_range(9) < 7);
            endcase
            if (pix_valid && pix_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected word", pix_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(pix_data == e, "R8 word order", pix_data, e);
                end
                last_pop = 1;
            end
        end
    end

    task automatic wait_quiet();
        int guard = 0;
        while (!(pend == 0 && !mem_req && exp_q.size() == 0 && !pix_valid) && guard < 5000) begin
            @(negedge clk); #1;
            guard++;
        end
    endtask

    task automatic wait_wraps(input int target);
        int guard = 0;
        while (wraps < target && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
        end
        check(wraps >= target, "R5 frames completed", 32'(wraps), 32'(target));
    endtask

    task automatic dma_restart();
        @(negedge clk); #1;
        cfg_dma_reset = 1'b1;
        @(negedge clk); #1;
        cfg_dma_reset = 1'b0;
        widx = 0;
        occ = 0;
        last_push = 0;
        last_pop = 0;
        exp_q.delete();
        check(!pix_valid && !mem_req, "R10 flushed and idle", 32'(pix_valid), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !pix_valid && !frame_start, "R1 idle in reset", 32'(mem_req), 32'h0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(!mem_req && !pix_valid && !frame_start, "R1 idle after reset", 32'(pix_valid), 32'h0);

        // frames of 22 words in bursts of 4 (last burst 2)
        rmode = 2;
        cfg_enable = 1'b1;
        wait_wraps(3);

        // consumer stalled: threshold decides
        rmode = 0;
        repeat (300) @(negedge clk);
        #1;
        check(!mem_req && pend == 0, "R6 no request when short of room", 32'(mem_req), 32'h0);
        check(DEPTH - occ < 21, "R6 free below threshold", 32'(DEPTH - occ), 32'd21);
        check(occ <= DEPTH, "R8 capacity", 32'(occ), 32'(DEPTH));
        rmode = 1;
        cfg_enable = 1'b0;
        wait_quiet();

        // new configuration after restart: bursts of 8, threshold 13
        cfg_burst_m1 = 4'd7;
        cfg_threshold = 6'd13;
        dma_restart();
        rmode = 2;
        cfg_enable = 1'b1;
        wait_wraps(5);

        // enable dropped right after a grant
        kill = 1;
        while (!kill_seen) begin @(negedge clk); #1; end
        begin
            int reqs = 0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk); #1;
                if (mem_req) reqs++;
            end
            check(reqs == 0, "R9 no request after disable", 32'(reqs), 32'h0);
            check(pend == 0 && exp_q.size() == 0, "R9 burst completed", 32'(pend), 32'h0);
        end

        // stray beats while idle
        wait_quiet();
        spur = 1;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); #1;
                if (pix_valid) seen++;
            end
            spur = 0;
            @(negedge clk); #1;
            if (pix_valid) seen++;
            check(seen == 0, "R11 stray beats dropped", 32'(seen), 32'h0);
        end

        // restart with a filled fifo, then length-limited refills
        rmode = 0;
        cfg_enable = 1'b1;
        repeat (200) @(negedge clk);
        cfg_enable = 1'b0;
        begin
            int guard = 0;
            while ((pend != 0 || mem_req) && guard < 2000) begin @(negedge clk); #1; guard++; end
        end
        #1;
        check(pix_valid == 1'b1, "R10 fifo holds words before restart", 32'(pix_valid), 32'h1);
        cfg_base_addr = 32'h0000_2000;
        cfg_frame_words = 20'd10;
        cfg_threshold = 6'd2;
        dma_restart();
        wraps = 0;
        cfg_enable = 1'b1;
        repeat (150) @(negedge clk);
        #1;
        check(DEPTH - occ < 8 && !mem_req, "R6 burst length limits refill", 32'(DEPTH - occ), 32'd8);
        rmode = 2;
        wait_wraps(3);
        rmode = 1;
        cfg_enable = 1'b0;
        wait_quiet();
        check(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule